// File: doc/BRIEF.md
# Shared Pixel Lookup Arbiter

This block lets several pixel-on-demand clients share one stateless glyph lookup. The clients are branches of a screen-composition tree: each asks for one pixel by presenting a request. A request holds a valid flag, an unsigned 12-bit column, an unsigned 12-bit row and an 8-bit character code. The tree is built so that, in normal use, at most one client is valid at a time. That is why one lookup is enough for all of them.

The arbiter takes the lowest-numbered valid request and passes its coordinate and code to the single lookup. It hands the returned one-bit-per-channel colour back to that client only. Every other client, and every client when no request is valid, sees black. A one-hot grant vector and a flag that reports no valid request are also brought out. The whole path is combinational, so a pixel arrives in the same cycle as its request.

A small test glyph lookup is built in. It uses 8x8 cells: the lit state of a pixel is bit `(x mod 8) XOR (y mod 8)` of the character code, and all three colour channels copy that bit.

Top module: `pix_share_arb`

## Requirements
- R1: `grant` is one-hot, with its single 1 at the lowest index whose `req_valid` bit is 1. It is all zero when no `req_valid` bit is set.
- R2: `none_valid` is 1 exactly when every `req_valid` bit is 0.
- R3: The granted port's `port_rgb` entry carries the lookup result for that port's own x, y and code. All three channels are equal: bit 2 is red, bit 1 is green and bit 0 is blue.
- R4: Every port that is not granted reads black (`3'b000`), whatever its own request holds.
- R5: With no valid request, every `port_rgb` entry is black.
- R6: The lookup pixel is lit when bit `(x[2:0] ^ y[2:0])` of the 8-bit code is 1. Bits x[11:3] and y[11:3] have no effect.
- R7: Outputs follow inputs with no register in the path, so a new request shows its pixel in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | N | Request valid flag per port |
| req_x | input | N x 12 | Column coordinate per port |
| req_y | input | N x 12 | Row coordinate per port |
| req_code | input | N x 8 | Character code per port |
| port_rgb | output | N x 3 | Colour returned per port (r,g,b = bits 2,1,0) |
| grant | output | N | One-hot selected port |
| none_valid | output | 1 | No request is valid |

## Verification
The hardest case to reach is several requests that are valid at once, because the intended use never produces it. Without it, the priority order and the blacking of losing ports go untested. The stimulus therefore drives all ports valid at once, and pairs of high-index ports valid together. It gives each port a different code and coordinate, so a wrong forward shows up as a wrong pixel. Coordinates with high bits set are mixed in to show that only the low three bits of x and y select the glyph bit.

// File: rtl/pix_share_pkg.sv
// Shared types and widths for the pixel lookup arbiter.
// Assumes: coordinates are unsigned; one colour bit per channel.
package pix_share_pkg;
    localparam int COORD_W = 12;
    localparam int CODE_W  = 8;
    localparam int CELL_W  = 3;   // log2 of glyph cell size (8x8)

    typedef struct packed {
        logic                valid;
        logic [COORD_W-1:0]  x;
        logic [COORD_W-1:0]  y;
        logic [CODE_W-1:0]   code;
    } pix_req_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } pix_rgb_t;
endpackage

// File: rtl/pix_share_prio.sv
// Fixed-priority picker: grants the lowest-indexed valid request.
// Assumes: nothing about how many requests are valid.
module pix_share_prio #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_in,
    output logic [N-1:0]     grant_out,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any_valid
);
    // Scan from the top down so the lowest valid index is written last.
    always_comb begin
        grant_out = '0;
        sel_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_in[i]) begin
                grant_out    = '0;
                grant_out[i] = 1'b1;
                sel_idx      = IDX_W'(i);
            end
        end
    end

    // Any request present at all.
    assign any_valid = |valid_in;

    // Guard the grant shape against the request vector.
    always_comb begin
        // R1
        grant_onehot_chk: assert ($onehot0(grant_out));
        // R2
        grant_empty_chk: assert ((grant_out == '0) == (valid_in == '0));
    end
endmodule

// File: rtl/pix_share_fwd.sv
// Forwards the selected port's request to the shared lookup.
// Assumes: sel_idx is in range; valid output drops when nothing is requested.
module pix_share_fwd
    import pix_share_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][COORD_W-1:0] req_x,
    input  logic [N-1:0][COORD_W-1:0] req_y,
    input  logic [N-1:0][CODE_W-1:0]  req_code,
    input  logic [IDX_W-1:0]          sel_idx,
    input  logic                      any_valid,
    output pix_req_t                  shared_req
);
    // Build the single request seen by the lookup.
    always_comb begin
        shared_req.valid = any_valid;
        shared_req.x     = req_x[sel_idx];
        shared_req.y     = req_y[sel_idx];
        shared_req.code  = req_code[sel_idx];
    end
endmodule

// File: rtl/pix_glyph_lookup.sv
// Stateless test glyph lookup with 8x8 cells.
// Pixel is lit when code bit (x[2:0] ^ y[2:0]) is set; all channels equal.
// Assumes: CODE_W covers 2**CELL_W bit positions.
module pix_glyph_lookup
    import pix_share_pkg::*;
(
    input  pix_req_t req,
    output pix_rgb_t pixel
);
    logic [CELL_W-1:0] bit_sel;
    logic              lit;

    // Cell column and row combine into one code-bit index.
    assign bit_sel = req.x[CELL_W-1:0] ^ req.y[CELL_W-1:0];

    // Select the glyph bit; black when no request is present.
    always_comb begin
        lit     = req.valid & req.code[bit_sel];
        pixel.r = lit;
        pixel.g = lit;
        pixel.b = lit;
    end
endmodule

// File: rtl/pix_share_arb.sv
// Top: lets N pixel clients share one glyph lookup.
// Picks the lowest valid port, forwards it, returns the pixel to it only.
// Assumes: at most one client valid in normal use; losers read black.
module pix_share_arb
    import pix_share_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]              req_valid,
    input  logic [N-1:0][COORD_W-1:0] req_x,
    input  logic [N-1:0][COORD_W-1:0] req_y,
    input  logic [N-1:0][CODE_W-1:0]  req_code,
    output logic [N-1:0][2:0]         port_rgb,
    output logic [N-1:0]              grant,
    output logic                      none_valid
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] sel_idx;
    logic             any_valid;
    pix_req_t         shared_req;
    pix_rgb_t         shared_pix;

    pix_share_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
        .valid_in  (req_valid),
        .grant_out (grant),
        .sel_idx   (sel_idx),
        .any_valid (any_valid)
    );

    pix_share_fwd #(.N(N), .IDX_W(IDX_W)) u_fwd (
        .req_x      (req_x),
        .req_y      (req_y),
        .req_code   (req_code),
        .sel_idx    (sel_idx),
        .any_valid  (any_valid),
        .shared_req (shared_req)
    );

    pix_glyph_lookup u_glyph (
        .req   (shared_req),
        .pixel (shared_pix)
    );

    // Flag the empty case for the clients.
    assign none_valid = ~any_valid;

    // Return path: only the granted port sees the shared pixel.
    for (genvar p = 0; p < N; p++) begin : g_ret
        always_comb begin
            port_rgb[p] = grant[p] ? {shared_pix.r, shared_pix.g, shared_pix.b} : 3'b000;
        end

        // Check each return lane against the grant.
        always_comb begin
            // R4
            loser_black_chk: assert (grant[p] || port_rgb[p] == 3'b000);
            // R3
            chan_equal_chk: assert (port_rgb[p] == 3'b000 || port_rgb[p] == 3'b111);
        end
    end

    // Empty-request check across all lanes.
    always_comb begin
        // R5
        idle_black_chk: assert (!none_valid || port_rgb == '0);
    end
endmodule

// File: tb/test_pix_share_arb.sv
// Bench: behavioural reference compared on every clock.
module test_pix_share_arb;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0]        req_valid = '0;
    logic [N-1:0][11:0]  req_x = '0;
    logic [N-1:0][11:0]  req_y = '0;
    logic [N-1:0][7:0]   req_code = '0;
    logic [N-1:0][2:0]   port_rgb;
    logic [N-1:0]        grant;
    logic                none_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pix_share_arb #(.N(N)) i_pix_share_arb (
        .req_valid  (req_valid),
        .req_x      (req_x),
        .req_y      (req_y),
        .req_code   (req_code),
        .port_rgb   (port_rgb),
        .grant      (grant),
        .none_valid (none_valid)
    );

    // Reference glyph: R6 rule on integers.
    function automatic int ref_pixel(int x, int y, int code);
        int idx;
        idx = (x % 8) ^ (y % 8);
        return (code >> idx) & 1;
    endfunction

    // Compare every output against the reference; R7: sampled in the same
    // cycle as the stimulus, with no clock edge in between.
    task automatic compare_all();
        int win;
        int exp_g;
        int exp_rgb;
        win = -1;
        for (int i = N - 1; i >= 0; i--) if (req_valid[i]) win = i;
        exp_g = (win < 0) ? 0 : (1 << win);
        checks++;
        if (grant !== N'(exp_g)) begin
            errors++;
            $display("FAIL R1 grant act=%b exp=%b", grant, N'(exp_g));
        end
        checks++;
        if (none_valid !== (win < 0)) begin
            errors++;
            $display("FAIL R2 none_valid act=%b exp=%b", none_valid, (win < 0));
        end
        for (int i = 0; i < N; i++) begin
            if (i == win) exp_rgb = ref_pixel(req_x[i], req_y[i], req_code[i]) ? 7 : 0;
            else          exp_rgb = 0;
            checks++;
            if (port_rgb[i] !== 3'(exp_rgb)) begin
                errors++;
                if (win < 0)
                    $display("FAIL R5 port %0d act=%b exp=%b", i, port_rgb[i], 3'(exp_rgb));
                else if (i == win)
                    $display("FAIL R3 R6 port %0d act=%b exp=%b", i, port_rgb[i], 3'(exp_rgb));
                else
                    $display("FAIL R4 port %0d act=%b exp=%b", i, port_rgb[i], 3'(exp_rgb));
            end
        end
    endtask

    // Drive just after a rising edge, check at the following falling edge.
    task automatic step(input logic [N-1:0] v);
        @(posedge clk);
        #1;
        req_valid = v;
        @(negedge clk);
        compare_all();
    endtask

    // Give each port a distinct code and coordinate.
    task automatic load_ports(input int base);
        for (int i = 0; i < N; i++) begin
            req_x[i]    = 12'(base * 37 + i * 5 + 12'h800 * (i % 2));
            req_y[i]    = 12'(base * 11 + i * 3 + 12'h400);
            req_code[i] = 8'(8'h5A ^ (base * 29 + i * 67));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state view: no request, all black (R5, R2)
        step('0);
        // Single valid port each (R3, R6)
        for (int b = 0; b < 8; b++) begin
            load_ports(b);
            for (int i = 0; i < N; i++) step(N'(1 << i));
        end
        // Simultaneous requests: priority and loser blacking (R1, R4)
        for (int b = 0; b < 8; b++) begin
            load_ports(b + 20);
            step('1);
            step(4'b1100);
            step(4'b1010);
            step(4'b0110);
        end
        // Full glyph sweep on port 0 with high coordinate bits set (R6)
        for (int c = 0; c < 4; c++) begin
            for (int x = 0; x < 8; x++) begin
                for (int y = 0; y < 8; y++) begin
                    req_x[0]    = 12'(x + 8 * (c * 97 + 1));
                    req_y[0]    = 12'(y + 8 * (c * 53 + 3));
                    req_code[0] = 8'(8'h01 << c) ^ 8'hC3;
                    step(4'b0001);
                end
            end
        end
        // Random mix, including idle cycles
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N; i++) begin
                req_x[i]    = 12'($urandom);
                req_y[i]    = 12'($urandom);
                req_code[i] = 8'($urandom);
            end
            step(N'($urandom));
        end
        step('0);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule